// File: doc/BRIEF.md
# ADC Conversion Sequencer with Register Interface

This block sits between a simple register bus and an external analog-to-digital converter core. Software programs a channel index, a clock divider, a resolution choice and a start bit through four word registers. The block then produces the converter clock from the system clock, hands the converter a latched channel number and a one-cycle start strobe, and waits for the converter's done pulse.

On done, the converter sample is trimmed to the chosen resolution and stored in a result register. A level interrupt is raised at the same time. It stays high until software writes a 1 to a dedicated clear register. A standby bit is passed straight to the converter, and while it is set no conversion can be launched. Start requests made while a conversion is pending or running are dropped; they are not queued.

Top module: `adc_conv_ctrl`

## Requirements
- R1: After reset, the control register at offset 0x00 reads 0x00004C40. This is a divider value of 49 in bits 13:6 with the divider enable bit 14 set; every other bit is 0. The result register and `irq` are 0.
- R2: Register offsets: control 0x00, result 0x0C, interrupt clear 0x18, channel select 0x1C. The channel index is held in bits 2:0 of the select register and is driven on `cnv_chan` when a conversion launches.
- R3: Control bit 16 set gives a 12-bit result. Control bit 16 clear keeps only the low 10 bits of the converter sample. Result bits above the selected width read 0.
- R4: Writing control with bit 0 set is accepted when the block is idle, standby is clear and the divider is enabled. `cnv_start` then pulses for one cycle at the second clock edge after the write. From then on, bit 0 reads 0 and busy (bit 15) reads 1 until the converter's done.
- R5: A start write made while a conversion is pending or busy is ignored and is not queued.
- R6: Control bit 2 (standby) drives `cnv_standby`. A start written together with standby never launches.
- R7: With the divider enable (bit 14) clear, a start never launches and `cnv_clk` stays low.
- R8: With the divider enabled, `cnv_clk` toggles once every (divider value + 1) system clocks.
- R9: Converter done while busy sets `irq`. Writing 1 in bit 0 to the clear register drops it. Writing 0 there has no effect.
- R10: If a clear write and a converter done fall on the same clock edge, `irq` ends up set.
- R11: The channel is latched at launch. Rewriting the select register during a conversion does not change `cnv_chan`.
- R12: A converter done while the block is not busy leaves the result register and `irq` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access valid |
| bus_we | input | 1 | Write strobe when selected |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| cnv_clk | output | 1 | Divided converter clock |
| cnv_chan | output | 3 | Channel latched at launch |
| cnv_start | output | 1 | One-cycle start strobe |
| cnv_standby | output | 1 | Parks the converter |
| cnv_done | input | 1 | Converter finished, sample valid |
| cnv_data | input | 12 | Converter sample |
| irq | output | 1 | Level conversion-complete interrupt |

## Verification
The interrupt has two sources that can land on the same clock edge: the converter's done pulse sets it, and a software write of 1 to the clear register drops it. To provoke the collision, the bench leaves the previous interrupt pending and starts a new conversion. It waits until the converter stub raises done, then drives the clear write in that same cycle so both are sampled at one edge. The check expects `irq` still high afterwards and the new sample in the result register, which shows the set wins and no completion is lost.

// File: rtl/adc_conv_ctrl.sv
module adc_conv_ctrl #(
  parameter int DATA_W  = 12,
  parameter int CH_W    = 3,
  parameter int PSC_W   = 8,
  parameter int PSC_RST = 49
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [7:0]        bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              cnv_clk,
  output logic [CH_W-1:0]   cnv_chan,
  output logic              cnv_start,
  output logic              cnv_standby,
  input  logic              cnv_done,
  input  logic [DATA_W-1:0] cnv_data,
  output logic              irq
);
  localparam logic [7:0] A_CTRL = 8'h00;
  localparam logic [7:0] A_DATA = 8'h0C;
  localparam logic [7:0] A_ICLR = 8'h18;
  localparam logic [7:0] A_CHAN = 8'h1C;
  localparam int B_STBY = 2;
  localparam int B_PSC  = 6;
  localparam int B_PEN  = B_PSC + PSC_W;
  localparam int B_RES  = B_PEN + 2;
  localparam int LO_W   = DATA_W - 2;

  logic              start_q, busy, psc_en, res_hi;
  logic [PSC_W-1:0]  psc_val, div_cnt;
  logic [CH_W-1:0]   chan_sel;
  logic [DATA_W-1:0] data_q, data_mask;

  wire wr      = bus_sel && bus_we;
  wire wr_ctrl = wr && bus_addr == A_CTRL;
  wire wr_chan = wr && bus_addr == A_CHAN;
  wire wr_clr  = wr && bus_addr == A_ICLR && bus_wdata[0];
  wire accept  = wr_ctrl && bus_wdata[0] && !busy && !start_q &&
                 !bus_wdata[B_STBY] && bus_wdata[B_PEN];
  wire capture = busy && cnv_done;
  wire unused_wdata = ^bus_wdata;

  assign data_mask = res_hi ? cnv_data : {2'b00, cnv_data[LO_W-1:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      psc_val     <= PSC_W'(PSC_RST);
      psc_en      <= 1'b1;
      res_hi      <= 1'b0;
      cnv_standby <= 1'b0;
      chan_sel    <= '0;
    end else begin
      if (wr_ctrl) begin
        psc_val     <= bus_wdata[B_PSC +: PSC_W];
        psc_en      <= bus_wdata[B_PEN];
        res_hi      <= bus_wdata[B_RES];
        cnv_standby <= bus_wdata[B_STBY];
      end
      if (wr_chan) chan_sel <= bus_wdata[CH_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q   <= 1'b0;
      busy      <= 1'b0;
      cnv_start <= 1'b0;
      cnv_chan  <= '0;
    end else begin
      cnv_start <= 1'b0;
      if (start_q) begin
        start_q   <= 1'b0;
        busy      <= 1'b1;
        cnv_start <= 1'b1;
        cnv_chan  <= chan_sel;
      end else begin
        if (accept) start_q <= 1'b1;
        if (capture) busy <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      irq    <= 1'b0;
    end else begin
      if (capture) data_q <= data_mask;
      if (capture)     irq <= 1'b1;
      else if (wr_clr) irq <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_cnt <= '0;
      cnv_clk <= 1'b0;
    end else if (!psc_en) begin
      div_cnt <= '0;
      cnv_clk <= 1'b0;
    end else if (div_cnt >= psc_val) begin
      div_cnt <= '0;
      cnv_clk <= ~cnv_clk;
    end else begin
      div_cnt <= div_cnt + 1'b1;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CTRL: begin
        bus_rdata[0]              = start_q;
        bus_rdata[B_STBY]         = cnv_standby;
        bus_rdata[B_PSC +: PSC_W] = psc_val;
        bus_rdata[B_PEN]          = psc_en;
        bus_rdata[B_PEN + 1]      = busy;
        bus_rdata[B_RES]          = res_hi;
      end
      A_DATA:  bus_rdata[DATA_W-1:0] = data_q;
      A_CHAN:  bus_rdata[CH_W-1:0]   = chan_sel;
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/adc_conv_ctrl_chk.sv
module adc_conv_ctrl_chk #(
  parameter int DATA_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              psc_en,
  input logic              cnv_clk,
  input logic              cnv_start,
  input logic              cnv_done,
  input logic              irq,
  input logic [DATA_W-1:0] data_q
);
  a_r4_start_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    cnv_start |=> !cnv_start);
  a_r4_start_marks_busy: assert property (@(posedge clk) disable iff (!rst_n)
    cnv_start |-> busy);
  a_r5_no_launch_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !cnv_start && !cnv_done) |=> !cnv_start);
  a_r7_clk_low_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !psc_en |=> !cnv_clk);
  a_r9_done_sets_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cnv_done) |=> irq);
  a_r12_result_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && cnv_done) |=> $stable(data_q));
endmodule

bind adc_conv_ctrl adc_conv_ctrl_chk #(.DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .busy(busy), .psc_en(psc_en), .cnv_clk(cnv_clk),
  .cnv_start(cnv_start), .cnv_done(cnv_done), .irq(irq), .data_q(data_q)
);

// File: tb/adc_conv_ctrl_tb_top.sv
`timescale 1ns/1ps
module adc_conv_ctrl_tb_top;
  logic        clk = 0, rst_n = 0;
  logic        bus_sel = 0, bus_we = 0;
  logic [7:0]  bus_addr = 8'h0C;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic        cnv_clk, cnv_start, cnv_standby, irq;
  logic [2:0]  cnv_chan;
  logic        cnv_done = 0;
  logic [11:0] cnv_data = 0;

  int n_run = 0, n_fail = 0, n_starts = 0, n_done = 0;
  logic [11:0] stub_val = 0;
  logic [2:0]  stub_ch = 0;
  bit spur = 0;
  logic [11:0] exp_q[$];
  logic [2:0]  ch_q[$];

  always #4 clk = ~clk;

  adc_conv_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cnv_clk(cnv_clk), .cnv_chan(cnv_chan), .cnv_start(cnv_start),
    .cnv_standby(cnv_standby), .cnv_done(cnv_done), .cnv_data(cnv_data),
    .irq(irq)
  );

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_we = 0; bus_addr = 8'h0C;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; #1 d = bus_rdata; bus_addr = 8'h0C;
  endtask

  function automatic logic [31:0] ctl(int psc, bit en, bit res, bit stby, bit go);
    return (32'(psc) << 6) | (32'(en) << 14) | (32'(res) << 16) |
           (32'(stby) << 2) | 32'(go);
  endfunction

  // converter stub: one start -> done after a fixed latency
  initial forever begin
    @(negedge clk);
    if (cnv_start) begin
      n_starts++;
      stub_ch = cnv_chan;
      repeat (5) @(posedge clk);
      #1 cnv_done = 1; cnv_data = stub_val;
      @(posedge clk);
      #1 cnv_done = 0;
    end
  end

  // monitor: compare the result register after each done
  initial forever begin
    @(posedge clk);
    if (cnv_done === 1'b1 && !spur) begin
      @(negedge clk); #2;
      if (exp_q.size() == 0) check("R2 unexpected done", 1, 0);
      else begin
        check("R3 result value", bus_rdata, {20'h0, exp_q.pop_front()});
        check("R2 channel at launch", {29'h0, stub_ch}, {29'h0, ch_q.pop_front()});
      end
      n_done++;
    end
  end

  task automatic conv(logic [2:0] ch, logic [11:0] v, bit res);
    int d0;
    d0 = n_done;
    stub_val = v;
    wr(8'h1C, {29'h0, ch});
    exp_q.push_back(res ? v : {2'b00, v[9:0]});
    ch_q.push_back(ch);
    wr(8'h00, ctl(49, 1, res, 0, 1));
    wait (n_done == d0 + 1);
  endtask

  initial begin
    #(8 * 100000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] r;
    int s0, n, d0;
    logic prev;
    repeat (3) @(negedge clk);
    rst_n = 1;
    rd(8'h00, r); check("R1 ctrl reset", r, 32'h0000_4C40);
    rd(8'h0C, r); check("R1 data reset", r, 0);
    check("R1 irq reset", {31'h0, irq}, 0);

    conv(3'd5, 12'hABC, 1);
    check("R9 irq set", {31'h0, irq}, 1);
    wr(8'h18, 0);
    check("R9 clear with 0 ignored", {31'h0, irq}, 1);
    wr(8'h18, 1);
    check("R9 clear", {31'h0, irq}, 0);
    conv(3'd2, 12'hABC, 0);
    wr(8'h18, 1);

    // R4 / R5 / R11: timing, busy, ignored restart, channel latch
    s0 = n_starts; d0 = n_done;
    stub_val = 12'h123;
    wr(8'h1C, 3'd6);
    exp_q.push_back(12'h123); ch_q.push_back(3'd6);
    wr(8'h00, ctl(49, 1, 1, 0, 1));
    rd(8'h00, r);
    check("R4 start reads 0", {31'h0, r[0]}, 0);
    check("R4 busy set", {31'h0, r[15]}, 1);
    check("R4 strobe seen", 32'(n_starts - s0), 1);
    wr(8'h1C, 3'd1);
    check("R11 chan held", {29'h0, cnv_chan}, 3'd6);
    wr(8'h00, ctl(49, 1, 1, 0, 1));
    wait (n_done == d0 + 1);
    repeat (20) @(negedge clk);
    check("R5 no queued start", 32'(n_starts - s0), 1);
    rd(8'h00, r); check("R4 busy cleared", {31'h0, r[15]}, 0);
    wr(8'h18, 1);

    // R6 standby
    s0 = n_starts;
    wr(8'h00, ctl(49, 1, 1, 1, 1));
    check("R6 standby out", {31'h0, cnv_standby}, 1);
    repeat (15) @(negedge clk);
    check("R6 no start in standby", 32'(n_starts - s0), 0);

    // R7 divider off
    wr(8'h00, ctl(49, 0, 1, 0, 1));
    n = 0;
    for (int i = 0; i < 15; i++) begin @(negedge clk); if (cnv_clk) n++; end
    check("R7 clk low", 32'(n), 0);
    check("R7 no start", 32'(n_starts - s0), 0);

    // R8 period
    wr(8'h00, ctl(3, 1, 1, 0, 0));
    @(negedge clk); prev = cnv_clk;
    for (int i = 0; i < 20 && cnv_clk == prev; i++) @(negedge clk);
    prev = cnv_clk; n = 0;
    for (int i = 0; i < 20 && cnv_clk == prev; i++) begin @(negedge clk); n++; end
    check("R8 half period", 32'(n), 4);

    // R12 spurious done
    rd(8'h0C, r);
    spur = 1;
    @(negedge clk); cnv_done = 1; cnv_data = 12'h555;
    @(negedge clk); cnv_done = 0;
    spur = 0;
    rd(8'h0C, bus_wdata); check("R12 data held", bus_wdata, r);
    check("R12 irq held", {31'h0, irq}, 0);

    // R10 collision: done and clear on one edge
    conv(3'd4, 12'h0F0, 1);
    d0 = n_done;
    stub_val = 12'h7E7;
    exp_q.push_back(12'h7E7); ch_q.push_back(3'd4);
    wr(8'h00, ctl(49, 1, 1, 0, 1));
    wait (cnv_done === 1'b1);
    bus_sel = 1; bus_we = 1; bus_addr = 8'h18; bus_wdata = 1;
    @(posedge clk); #1;
    bus_sel = 0; bus_we = 0; bus_addr = 8'h0C;
    wait (n_done == d0 + 1);
    @(negedge clk);
    check("R10 set wins over clear", {31'h0, irq}, 1);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule